// File: doc/BRIEF.md
# Register-Mapped Serial Flash Controller

A memory-mapped controller that runs single-lane SPI flash transactions on behalf of software. Software writes an instruction value, an address, a header count that says how many instruction bytes and how many address bytes to send, an optional read byte count and a direction, then sets a start bit. The controller shifts the header out most significant byte first, then either sends bytes taken from an 8-entry transmit FIFO (write direction) or clocks in bytes into an 8-entry receive FIFO (read direction).

Start, stop and FIFO flush are self-clearing bits that software polls, so the whole protocol is run by register reads and writes: raise chip select, poll the ready flag, program the header, start, move data through the data ports, wait for ready with an empty transmit FIFO, request a stop, poll until the start bit falls, drop chip select. SCLK runs in SPI mode 0 at half the system clock. Register offsets are fixed because software decodes them: 0x00 control/status, 0x04 configuration, 0x08 data-out, 0x0C data-in, 0x10 instruction, 0x14 address, 0x1C header count, 0x20 read count; any other offset reads as zero.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset chip select is high, SCLK is low, the control/status register reads 0x52 (ready at bit 1, receive-empty at bit 4, transmit-empty at bit 6, all else zero) and the configuration register reads 0.
- R2: SCLK idles low, has a period of two system clocks, and MOSI changes only while SCLK is low, so every byte is captured MSB first on rising SCLK edges.
- R3: Header count bits 3:0 give the instruction byte count and bits 7:4 the address byte count; instruction bytes come first, then address bytes, each taken from the low bytes of its register most significant first; a count above 4 acts as 4.
- R4: In read direction (configuration bit 13 = 0) with a nonzero read count N, exactly N bytes are clocked after the header; each appears in bits 7:0 of the data-in port, and reading that port pops the receive FIFO.
- R5: With a read count of 0 the controller keeps clocking bytes in, stalls with SCLK idle while the receive FIFO holds 8 bytes, and resumes once a byte is popped.
- R6: In write direction (bit 13 = 1) bytes written to data-out follow the header; SCLK stays idle while the transmit FIFO is empty; status bit 7 shows a full transmit FIFO and a write while it is full is dropped.
- R7: A stop request (configuration bit 14) is honoured only once the header is sent, no byte is in flight and the transmit FIFO is empty; then start (bit 15) and stop both read as 0. A stop written with no transfer running is ignored.
- R8: Writing configuration bit 9 empties both FIFOs; the bit reads 1 for one cycle and then clears by itself.
- R9: Status bit 1 (ready) is 0 while a byte is being shifted or about to be launched, and in the cycle after chip-select enable (control bit 0) changes value; otherwise it is 1.
- R10: The lane-width field, configuration bits 12:10, always reads 0 and nonzero writes to it have no effect; transfers stay single-lane.
- R11: The start bit reads 1 for the whole transfer, and writing start again while a transfer runs does not restart it or resend the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The embedded assertions watch, on every cycle, that MOSI holds while SCLK is high, that neither FIFO is pushed when full or popped when empty, that SCLK is silent whenever no transfer is active, that a transfer only ends after a pending stop with an empty transmit FIFO, that a flush leaves both FIFOs empty, and that ready drops right after chip select toggles. Byte order of the header, the clamping of counts, the exact number of bytes in a counted read, the stall and resume of an open-ended read, dropped writes to a full FIFO and the ignored lane and repeated-start writes only show up in the bench's scenarios, where a flash model logs MOSI bytes and feeds known MISO bytes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [5:0] ADR_CTRL  = 6'h00;
  localparam logic [5:0] ADR_CONF  = 6'h04;
  localparam logic [5:0] ADR_DOUT  = 6'h08;
  localparam logic [5:0] ADR_DIN   = 6'h0C;
  localparam logic [5:0] ADR_INSTR = 6'h10;
  localparam logic [5:0] ADR_ADDR  = 6'h14;
  localparam logic [5:0] ADR_HDR   = 6'h1C;
  localparam logic [5:0] ADR_DCNT  = 6'h20;

  localparam int MAX_HDR_BYTES = 4;

  // header byte counts saturate at the register width in bytes
  function automatic logic [2:0] clamp_cnt(input logic [3:0] n);
    return (n > 4'(MAX_HDR_BYTES)) ? 3'(MAX_HDR_BYTES) : n[2:0];
  endfunction
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    wp_d = wp_q + {{AW{1'b0}}, push};
    rp_d = rp_q + {{AW{1'b0}}, pop};
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp_q[AW-1:0]] <= din;
  end

  assign dout  = mem[rp_q[AW-1:0]];
  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

  AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R5, R6
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R4
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] dout,
  output logic       sclk,
  output logic       mosi
);
  logic [7:0] sh_q, sh_d;
  logic       busy_q, busy_d, ph_q, ph_d, done_q, done_d;
  logic [2:0] bc_q, bc_d;

  always_comb begin
    sh_d   = sh_q;
    busy_d = busy_q;
    ph_d   = ph_q;
    bc_d   = bc_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        sh_d   = din;
        busy_d = 1'b1;
        ph_d   = 1'b0;
        bc_d   = '0;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      sh_d = {sh_q[6:0], miso};
      bc_d = bc_q + 3'd1;
      if (bc_q == 3'd7) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      busy_q <= busy_d;
      ph_q   <= ph_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign dout = sh_q;
  assign sclk = busy_q & ph_q;
  assign mosi = busy_q & sh_q[7];

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi));  // R2
  AST_LAUNCH_FREE:    assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy_q);      // R2
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq import sfc_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic             dir_wr,
  input  logic [3:0]       icnt,
  input  logic [3:0]       acnt,
  input  logic [31:0]      instr,
  input  logic [31:0]      addr,
  input  logic [CNT_W-1:0] dcnt,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  input  logic             rx_full,
  input  logic             eng_busy,
  input  logic             eng_done,
  output logic             launch,
  output logic [7:0]       launch_byte,
  output logic             tx_pop,
  output logic             rx_push,
  output logic             active,
  output logic             stop_pend
);
  logic             act_q, act_d, stp_q, stp_d, open_q, open_d, dat_q, dat_d;
  logic [2:0]       ic_q, ic_d, ac_q, ac_d, ism, asm_;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             eng_free;

  assign eng_free = !eng_busy && !eng_done;
  assign ism  = ic_q - 3'd1;
  assign asm_ = ac_q - 3'd1;

  always_comb begin
    act_d = act_q; stp_d = stp_q; open_d = open_q; dat_d = dat_q;
    ic_d = ic_q; ac_d = ac_q; rem_d = rem_q;
    launch = 1'b0; launch_byte = 8'h00; tx_pop = 1'b0;
    if (act_q && eng_free) begin
      if (ic_q != 3'd0) begin
        launch = 1'b1; dat_d = 1'b0; ic_d = ism;
        launch_byte = 8'(instr >> {ism[1:0], 3'b000});
      end else if (ac_q != 3'd0) begin
        launch = 1'b1; dat_d = 1'b0; ac_d = asm_;
        launch_byte = 8'(addr >> {asm_[1:0], 3'b000});
      end else if (stp_q && tx_empty) begin
        act_d = 1'b0; stp_d = 1'b0;
      end else if (dir_wr) begin
        if (!tx_empty) begin
          launch = 1'b1; dat_d = 1'b1; tx_pop = 1'b1;
          launch_byte = tx_data;
        end
      end else if ((open_q || rem_q != '0) && !rx_full) begin
        launch = 1'b1; dat_d = 1'b1;
        if (!open_q) rem_d = rem_q - 1'b1;
      end
    end
    if (start_wr && !act_q) begin
      act_d = 1'b1; stp_d = 1'b0; dat_d = 1'b0;
      ic_d = clamp_cnt(icnt); ac_d = clamp_cnt(acnt);
      rem_d = dcnt; open_d = (dcnt == '0);
    end
    if (stop_wr && act_q && act_d) stp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; stp_q <= 1'b0; open_q <= 1'b0; dat_q <= 1'b0;
      ic_q <= '0; ac_q <= '0; rem_q <= '0;
    end else begin
      act_q <= act_d; stp_q <= stp_d; open_q <= open_d; dat_q <= dat_d;
      ic_q <= ic_d; ac_q <= ac_d; rem_q <= rem_d;
    end
  end

  assign rx_push   = eng_done && dat_q && !dir_wr;
  assign active    = act_q;
  assign stop_pend = stp_q;

  AST_END_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(stp_q) && $past(tx_empty) && !eng_busy);  // R7
  AST_NO_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !launch);  // R7
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl import sfc_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic             cs_en_q, cs_en_d, cs_d_q, dir_q, dir_d, flush_q, flush_d;
  logic [31:0]      instr_q, instr_d, addr_q, addr_d;
  logic [7:0]       hdr_q, hdr_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             wr, rd, wr_conf, start_wr, stop_wr;
  logic             tx_push, tx_pop, tx_empty, tx_full, rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]       tx_data, rx_data, eng_byte, launch_byte;
  logic             launch, eng_busy, eng_done, active, stop_pend, ready;

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign wr_conf  = wr && (bus_addr == ADR_CONF);
  assign start_wr = wr_conf && bus_wdata[15];
  assign stop_wr  = wr_conf && bus_wdata[14];
  assign tx_push  = wr && (bus_addr == ADR_DOUT) && !tx_full;
  assign rx_pop   = rd && (bus_addr == ADR_DIN) && !rx_empty;

  always_comb begin
    cs_en_d = cs_en_q; dir_d = dir_q; flush_d = 1'b0;
    instr_d = instr_q; addr_d = addr_q; hdr_d = hdr_q; dcnt_d = dcnt_q;
    if (wr) begin
      case (bus_addr)
        ADR_CTRL:  cs_en_d = bus_wdata[0];
        ADR_CONF: begin
          if (!active) dir_d = bus_wdata[13];
          flush_d = bus_wdata[9];
        end
        ADR_INSTR: instr_d = bus_wdata;
        ADR_ADDR:  addr_d  = bus_wdata;
        ADR_HDR:   hdr_d   = bus_wdata[7:0];
        ADR_DCNT:  dcnt_d  = bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cs_en_q <= 1'b0; cs_d_q <= 1'b0; dir_q <= 1'b0; flush_q <= 1'b0;
      instr_q <= '0; addr_q <= '0; hdr_q <= '0; dcnt_q <= '0;
    end else begin
      cs_en_q <= cs_en_d; cs_d_q <= cs_en_q; dir_q <= dir_d; flush_q <= flush_d;
      instr_q <= instr_d; addr_q <= addr_d; hdr_q <= hdr_d; dcnt_q <= dcnt_d;
    end
  end

  assign ready = (cs_d_q == cs_en_q) && !eng_busy && !eng_done && !launch;

  always_comb begin
    case (bus_addr)
      ADR_CTRL:  bus_rdata = {24'h0, tx_full, tx_empty, 1'b0, rx_empty, 2'b00, ready, cs_en_q};
      ADR_CONF:  bus_rdata = {16'h0, active, stop_pend, dir_q, 3'b000, flush_q, 9'h000};
      ADR_DIN:   bus_rdata = {24'h0, rx_empty ? 8'h00 : rx_data};
      ADR_INSTR: bus_rdata = instr_q;
      ADR_ADDR:  bus_rdata = addr_q;
      ADR_HDR:   bus_rdata = {24'h0, hdr_q};
      ADR_DCNT:  bus_rdata = 32'(dcnt_q);
      default:   bus_rdata = 32'h0;
    endcase
  end

  sfc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .clr(flush_q), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full));

  sfc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .clr(flush_q), .push(rx_push), .din(eng_byte),
    .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .full(rx_full));

  sfc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .start_wr(start_wr), .stop_wr(stop_wr), .dir_wr(dir_q),
    .icnt(hdr_q[3:0]), .acnt(hdr_q[7:4]), .instr(instr_q), .addr(addr_q), .dcnt(dcnt_q),
    .tx_empty(tx_empty), .tx_data(tx_data), .rx_full(rx_full),
    .eng_busy(eng_busy), .eng_done(eng_done), .launch(launch), .launch_byte(launch_byte),
    .tx_pop(tx_pop), .rx_push(rx_push), .active(active), .stop_pend(stop_pend));

  sfc_shift u_shift (
    .clk(clk), .rst_n(rst_i), .start(launch), .din(launch_byte), .miso(spi_miso),
    .busy(eng_busy), .done(eng_done), .dout(eng_byte), .sclk(spi_sclk), .mosi(spi_mosi));

  assign spi_cs_n = !cs_en_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_i)
    $past(flush_q) |-> rx_empty && tx_empty);  // R8
  AST_READY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_i)
    (cs_en_q != $past(cs_en_q)) |-> !ready);  // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    !active |-> !spi_sclk);  // R7
endmodule

// File: tb/tb_spi_flash_ctrl.sv
module tb_spi_flash_ctrl;
  logic        clk, rst_n, bus_en, bus_we, spi_miso;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;

  spi_flash_ctrl dut (.*);

  int n_chk = 0, n_fail = 0, mlen = 0, sbit = 0, bad_period = 0;
  bit finished = 0;
  logic [7:0] mlog [64];
  logic [7:0] shreg = 8'h00;
  time t_last = 0;

  function automatic logic [7:0] mb(input int k);
    return 8'hA5 ^ 8'(k * 29);
  endfunction

  initial begin clk = 0; forever #2 clk = ~clk; end

  // flash model: logs MOSI bytes, serves MISO byte k = mb(k) from chip-select fall
  initial forever begin
    @(posedge spi_sclk);
    if ((sbit % 8) != 0 && ($time - t_last) != 8) bad_period++;
    t_last = $time;
    shreg = {shreg[6:0], spi_mosi};
    sbit++;
    if ((sbit % 8) == 0 && mlen < 64) begin mlog[mlen] = shreg; mlen++; end
  end
  initial forever begin
    logic [7:0] b;
    @(negedge spi_sclk); #1;
    b = mb(sbit / 8);
    spi_miso = b[7 - (sbit % 8)];
  end
  initial forever begin
    logic [7:0] b;
    @(negedge spi_cs_n);
    sbit = 0; mlen = 0; b = mb(0); spi_miso = b[7];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_en = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(6'h00, s);
      if (s[1]) return;
    end
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(6'h04, s);
      if (!s[15]) return;
    end
  endtask

  task automatic cs_cycle();
    wr(6'h00, 32'h0); wr(6'h00, 32'h1); wait_ready();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 cs/sclk", {spi_cs_n, spi_sclk}, 32'h2);
    rd(6'h00, d); chk(d == 32'h52, "R1 status", d, 32'h52);
    rd(6'h04, d); chk(d == 32'h0, "R1 conf", d, 32'h0);
  endtask

  task automatic t_ready_lane();
    logic [31:0] d;
    wr(6'h00, 32'h1);
    rd(6'h00, d); chk(d[1] == 1'b0, "R9 ready low after cs change", d[1], 0);
    rd(6'h00, d); chk(d[1] == 1'b1, "R9 ready back", d[1], 1);
    chk(spi_cs_n === 1'b0, "R9 cs asserted", spi_cs_n, 0);
    wr(6'h04, 32'h1C00);
    rd(6'h04, d); chk(d == 32'h0, "R10 lane field reads 0", d, 0);
    wr(6'h04, 32'h4000);
    rd(6'h04, d); chk(d == 32'h0, "R7 stop ignored when idle", d, 0);
  endtask

  task automatic t_header_write();
    logic [31:0] d;
    cs_cycle();
    wr(6'h10, 32'h0000_0A9F); wr(6'h14, 32'h0012_3456); wr(6'h1C, 32'h32);
    wr(6'h04, 32'hBC00);             // start, write direction, lane bits set
    wait_ready();
    chk(mlen == 5, "R3 header length", mlen, 5);
    chk(mlog[0] == 8'h0A && mlog[1] == 8'h9F, "R3 instruction order", {mlog[0], mlog[1]}, 32'h0A9F);
    chk(mlog[2] == 8'h12 && mlog[3] == 8'h34 && mlog[4] == 8'h56, "R10 R3 address order",
        {mlog[2], mlog[3], mlog[4]}, 32'h123456);
    repeat (10) @(posedge clk);
    #1 chk(spi_sclk == 1'b0 && mlen == 5, "R6 idle while transmit FIFO empty", mlen, 5);
    wr(6'h04, 32'hA000);             // repeated start
    repeat (10) @(posedge clk);
    rd(6'h04, d); chk(d[15] == 1'b1 && mlen == 5, "R11 start held, no restart", {d[15], 8'(mlen)}, 32'h105);
    wr(6'h08, 32'hC3); wr(6'h08, 32'h3C);
    wait_ready();
    chk(mlen == 7 && mlog[5] == 8'hC3 && mlog[6] == 8'h3C, "R6 data after header",
        {mlog[5], mlog[6]}, 32'hC33C);
    chk(bad_period == 0, "R2 SCLK period two clocks", bad_period, 0);
    wr(6'h04, 32'hE000);
    wait_done();
    rd(6'h04, d); chk(d[15:14] == 2'b00, "R7 start and stop cleared", d[15:14], 0);
  endtask

  task automatic t_clamp();
    cs_cycle();
    wr(6'h10, 32'h1122_3344); wr(6'h1C, 32'h07);
    wr(6'h04, 32'hA000);
    wait_ready();
    chk(mlen == 4 && mlog[0] == 8'h11 && mlog[3] == 8'h44, "R3 count clamped to 4",
        {8'(mlen), mlog[0], mlog[3]}, 32'h041144);
    wr(6'h04, 32'h6000); wait_done();
  endtask

  task automatic t_read_count();
    logic [31:0] d;
    cs_cycle();
    wr(6'h04, 32'h0200);
    wr(6'h10, 32'h03); wr(6'h14, 32'h100); wr(6'h1C, 32'h31); wr(6'h20, 32'd3);
    wr(6'h04, 32'h8000);
    wait_ready();
    repeat (20) @(posedge clk);
    chk(mlen == 7, "R4 exactly N bytes clocked", mlen, 7);
    for (int i = 0; i < 3; i++) begin
      rd(6'h0C, d); chk(d == 32'(mb(4 + i)), "R4 data-in byte", d, 32'(mb(4 + i)));
    end
    rd(6'h00, d); chk(d[4] == 1'b1, "R4 receive FIFO drained", d[4], 1);
    wr(6'h04, 32'h4000); wait_done();
  endtask

  task automatic t_open_read();
    logic [31:0] d;
    cs_cycle();
    wr(6'h10, 32'h05); wr(6'h1C, 32'h01); wr(6'h20, 32'd0);
    wr(6'h04, 32'h8000);
    wait_ready();
    repeat (20) @(posedge clk);
    chk(mlen == 9, "R5 stall at full FIFO", mlen, 9);
    rd(6'h0C, d); chk(d == 32'(mb(1)), "R5 first byte", d, 32'(mb(1)));
    rd(6'h0C, d); chk(d == 32'(mb(2)), "R5 second byte", d, 32'(mb(2)));
    wait_ready();
    repeat (20) @(posedge clk);
    chk(mlen == 11, "R5 resumes after pop", mlen, 11);
    wr(6'h04, 32'h4000); wait_done();
    rd(6'h04, d); chk(d[15] == 1'b0, "R7 open read stopped", d[15], 0);
    wr(6'h04, 32'h0200);
    rd(6'h04, d); chk(d[9] == 1'b1, "R8 flush bit visible", d[9], 1);
    rd(6'h04, d); chk(d[9] == 1'b0, "R8 flush bit self-clears", d[9], 0);
    rd(6'h00, d); chk(d[4] == 1'b1, "R8 receive FIFO emptied", d[4], 1);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    cs_cycle();
    for (int i = 0; i < 9; i++) wr(6'h08, 32'(8'h40 + i));
    rd(6'h00, d); chk(d[7:6] == 2'b10, "R6 full flag", d[7:6], 2);
    wr(6'h1C, 32'h00);
    wr(6'h04, 32'hA000);
    wr(6'h04, 32'hE000);             // stop requested with bytes still queued
    wait_done();
    chk(mlen == 8 && mlog[7] == 8'h47, "R7 R6 queue drained before stop, ninth dropped",
        {8'(mlen), mlog[7]}, 32'h0847);
    wr(6'h08, 32'h11); wr(6'h08, 32'h22);
    wr(6'h04, 32'h2200);
    rd(6'h00, d); rd(6'h00, d);
    chk(d[6] == 1'b1, "R8 transmit FIFO emptied", d[6], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; spi_miso = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_ready_lane();
    t_header_write();
    t_clamp();
    t_read_count();
    t_open_read();
    t_tx_full();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule